// File: doc/BRIEF.md
# Reset Sequencer with Supply-Loss Flag

This block drives the active-low system reset of a small microcontroller and records why the last reset happened. Its inputs are a digital supply-good level from an external voltage comparator, a watchdog reset request and a reset request from an external pin. A status word that software reads holds one flag per cause.

Loss of supply pulls reset low at once. When the supply returns, a long stabilisation count holds reset low for a fixed number of cycles before release. Watchdog and pin requests give a short fixed reset. The supply-loss flag is set by supply events and cleared by the short causes. Software can write 1 to that flag to start a full supply-style reset. The restart address is presented as a constant.

The watchdog and pin request inputs are synchronous to the clock. The supply-good input is asynchronous.

Top module: `rstc_top`

## Requirements
- R1: While `supply_ok_i` is low, `rst_n_o` is low, and it goes low as soon as the supply input falls, without waiting for a clock edge.
- R2: After `supply_ok_i` rises, `rst_n_o` stays low through the synchroniser latency (SYNC_STAGES edges) and then POR_CYCLES more edges. It is high after edge SYNC_STAGES+POR_CYCLES counted from the rise.
- R3: On leaving a supply reset, bit 0 of `csr_rdata_o` (the supply-loss flag) reads 1. Status bit positions are: bit 0 supply-loss, bit 1 watchdog, bit 2 pin.
- R4: A watchdog or pin request sampled at a clock edge drives `rst_n_o` low from that edge, for exactly SHORT_CYCLES cycles.
- R5: A watchdog or pin reset clears bit 0 and sets only the bit of its own cause: watchdog gives 3'b010, pin gives 3'b100.
- R6: A write while running with bit 0 of `csr_wdata_i` set starts a long reset. `rst_n_o` is low for POR_CYCLES cycles from the write edge, and the status reads 3'b001 afterwards.
- R7: A request that arrives while reset is counting restarts the count. During a long count, a short-cause request keeps the long length and leaves the status unchanged.
- R8: A write with bit 0 clear changes nothing: reset stays high and the status keeps its value, whatever bits 1 and 2 hold.
- R9: `rst_vec_o` always reads the restart address RST_VEC, which defaults to 0x0000.
- R10: A supply drop during operation, followed by a return, repeats the R2 timing and sets bit 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| supply_ok_i | input | 1 | Asynchronous supply-good level, high when the supply is valid |
| wdog_req_i | input | 1 | Watchdog reset request, synchronous |
| pin_req_i | input | 1 | External-pin reset request, synchronous |
| csr_wr_i | input | 1 | Status register write strobe |
| csr_wdata_i | input | 3 | Status register write data |
| csr_rdata_o | output | 3 | Reset cause status: supply-loss, watchdog, pin |
| rst_n_o | output | 1 | Active-low system reset |
| rst_vec_o | output | VEC_W | Constant restart address |

## Verification
The reset output and the status are tried under these patterns:
- a cold supply rise;
- single watchdog and pin pulses;
- a pin pulse landing mid-count;
- a watchdog pulse landing inside a software-forced long count;
- status writes with bit 0 clear;
- a supply drop in operation.

The cold rise fixes the long-count length. The single pulses separate the short length and the flag encoding of each cause. The mid-count pulse shows that the counter restarts rather than running out. The pulse inside a forced count tells cause priority apart from a plain restart. The writes with bit 0 clear, and the supply drop, show that only a 1 in bit 0 or a supply event starts the long path.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
   localparam int unsigned CAUSE_W  = 3;
   localparam int unsigned BIT_SUPP = 0;
   localparam int unsigned BIT_WDOG = 1;
   localparam int unsigned BIT_PIN  = 2;
   typedef logic [CAUSE_W-1:0] cause_t;
   localparam cause_t CAUSE_SUPPLY = cause_t'(1 << BIT_SUPP);
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic arst_n_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rstc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge arst_n_i) begin
         if (!arst_n_i)   chain_q[i] <= 1'b0;
         else if (i == 0) chain_q[i] <= 1'b1;
         else             chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rstc_timer.sv
module rstc_timer #(
   parameter int unsigned LONG_CYCLES  = 64,
   parameter int unsigned SHORT_CYCLES = 16
) (
   input  logic clk_i,
   input  logic pwr_ok_i,
   input  logic pwr_ok_q_i,
   input  logic start_long_i,
   input  logic start_short_i,
   output logic active_o,
   output logic long_o
);
   localparam int unsigned CNT_W = $clog2(LONG_CYCLES);

   if (SHORT_CYCLES < 2) begin : g_bad_short
      $error("rstc_timer: SHORT_CYCLES must be at least 2");
   end
   if (LONG_CYCLES <= SHORT_CYCLES) begin : g_bad_long
      $error("rstc_timer: LONG_CYCLES must exceed SHORT_CYCLES");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last;
   logic             active_q, long_q;
   logic             start;

   assign start = start_long_i | start_short_i;
   assign last  = long_q ? CNT_W'(LONG_CYCLES - 1) : CNT_W'(SHORT_CYCLES - 1);

   always_ff @(posedge clk_i or negedge pwr_ok_i) begin
      if (!pwr_ok_i) begin
         cnt_q    <= '0;
         active_q <= 1'b1;
         long_q   <= 1'b1;
      end else if (!pwr_ok_q_i) begin
         cnt_q    <= '0;
         active_q <= 1'b1;
         long_q   <= 1'b1;
      end else if (start) begin
         cnt_q    <= '0;
         active_q <= 1'b1;
         long_q   <= start_long_i | (active_q & long_q);
      end else if (active_q) begin
         if (cnt_q == last) active_q <= 1'b0;
         else               cnt_q    <= cnt_q + 1'b1;
      end
   end

   assign active_o = active_q;
   assign long_o   = long_q;

   assert_restart_R7: assert property (@(posedge clk_i) disable iff (!pwr_ok_q_i)
      start |=> (active_q && cnt_q == '0));
   assert_exit_at_limit_R2: assert property (@(posedge clk_i) disable iff (!pwr_ok_q_i)
      $fell(active_q) |-> ($past(cnt_q) == $past(last)));
   assert_long_kept_R7: assert property (@(posedge clk_i) disable iff (!pwr_ok_q_i)
      (active_q && long_q && start_short_i) |=> long_q);
endmodule

// File: rtl/rstc_cause.sv
module rstc_cause
   import rstc_pkg::*;
(
   input  logic   clk_i,
   input  logic   pwr_ok_i,
   input  logic   pwr_ok_q_i,
   input  logic   sw_force_i,
   input  logic   wdog_i,
   input  logic   pin_i,
   input  logic   hold_long_i,
   output cause_t cause_o
);
   cause_t cause_q;
   logic   short_req;

   assign short_req = wdog_i | pin_i;

   always_ff @(posedge clk_i or negedge pwr_ok_i) begin
      if (!pwr_ok_i)                      cause_q <= CAUSE_SUPPLY;
      else if (!pwr_ok_q_i)               cause_q <= CAUSE_SUPPLY;
      else if (sw_force_i)                cause_q <= CAUSE_SUPPLY;
      else if (short_req && !hold_long_i) begin
         cause_q           <= '0;
         cause_q[BIT_WDOG] <= wdog_i;
         cause_q[BIT_PIN]  <= pin_i;
      end
   end

   assign cause_o = cause_q;

   assert_force_sets_supply_R6: assert property (@(posedge clk_i) disable iff (!pwr_ok_q_i)
      sw_force_i |=> (cause_q == CAUSE_SUPPLY));
   assert_short_clears_supply_R5: assert property (@(posedge clk_i) disable iff (!pwr_ok_q_i)
      (short_req && !hold_long_i && !sw_force_i) |=> !cause_q[BIT_SUPP]);
   assert_idle_stable_R8: assert property (@(posedge clk_i) disable iff (!pwr_ok_q_i)
      (!sw_force_i && !short_req) |=> $stable(cause_q));
   assert_priority_R7: assert property (@(posedge clk_i) disable iff (!pwr_ok_q_i)
      (short_req && hold_long_i && !sw_force_i) |=> $stable(cause_q));
endmodule

// File: rtl/rstc_top.sv
module rstc_top
   import rstc_pkg::*;
#(
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned POR_CYCLES   = 64,
   parameter int unsigned SHORT_CYCLES = 16,
   parameter int unsigned VEC_W        = 16,
   parameter logic [VEC_W-1:0] RST_VEC = '0
) (
   input  logic               clk_i,
   input  logic               supply_ok_i,
   input  logic               wdog_req_i,
   input  logic               pin_req_i,
   input  logic               csr_wr_i,
   input  logic [CAUSE_W-1:0] csr_wdata_i,
   output logic [CAUSE_W-1:0] csr_rdata_o,
   output logic               rst_n_o,
   output logic [VEC_W-1:0]   rst_vec_o
);
   logic   ok_q, active, long_mode, sw_force;
   cause_t cause;

   rstc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i    (clk_i),
      .arst_n_i (supply_ok_i),
      .q_o      (ok_q)
   );

   assign sw_force = csr_wr_i & csr_wdata_i[BIT_SUPP] & ~active;

   rstc_timer #(.LONG_CYCLES(POR_CYCLES), .SHORT_CYCLES(SHORT_CYCLES)) u_timer (
      .clk_i         (clk_i),
      .pwr_ok_i      (supply_ok_i),
      .pwr_ok_q_i    (ok_q),
      .start_long_i  (sw_force),
      .start_short_i (wdog_req_i | pin_req_i),
      .active_o      (active),
      .long_o        (long_mode)
   );

   rstc_cause u_cause (
      .clk_i       (clk_i),
      .pwr_ok_i    (supply_ok_i),
      .pwr_ok_q_i  (ok_q),
      .sw_force_i  (sw_force),
      .wdog_i      (wdog_req_i),
      .pin_i       (pin_req_i),
      .hold_long_i (active & long_mode),
      .cause_o     (cause)
   );

   assign rst_n_o     = ~active;
   assign csr_rdata_o = cause;
   assign rst_vec_o   = RST_VEC;

   assert_exit_sets_supply_R3: assert property (@(posedge clk_i) disable iff (!ok_q)
      ($rose(rst_n_o) && long_mode) |-> csr_rdata_o[BIT_SUPP]);
   assert_short_sets_cause_R4: assert property (@(posedge clk_i) disable iff (!ok_q)
      (wdog_req_i && !(active && long_mode) && !sw_force) |=> (!rst_n_o && csr_rdata_o[BIT_WDOG]));
endmodule

// File: tb/tb_rstc_top.sv
module tb_rstc_top;
   localparam int CLK_PERIOD = 10;
   localparam int SYNC  = 2;
   localparam int POR   = 64;
   localparam int SHORT = 16;

   logic       clk = 1'b0;
   logic       supply = 1'b1;
   logic       wdog = 1'b0, pin = 1'b0, wr = 1'b0;
   logic [2:0] wdata = '0;
   logic [2:0] rdata;
   logic       rst_n;
   logic [15:0] vec;

   int n_vec = 0, n_bad = 0, cyc = 0;
   bit done = 0;

   typedef struct {
      int         at;
      logic       rst;
      logic [2:0] flags;
      logic [2:0] mask;
      string      tag;
   } item_t;
   item_t sb[$];

   rstc_top #(.SYNC_STAGES(SYNC), .POR_CYCLES(POR), .SHORT_CYCLES(SHORT)) dut (
      .clk_i(clk), .supply_ok_i(supply), .wdog_req_i(wdog), .pin_req_i(pin),
      .csr_wr_i(wr), .csr_wdata_i(wdata), .csr_rdata_o(rdata),
      .rst_n_o(rst_n), .rst_vec_o(vec)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
      end
   endtask

   task automatic push(int at, logic r, logic [2:0] f, logic [2:0] m, string tag);
      item_t it;
      it.at = at; it.rst = r; it.flags = f; it.mask = m; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic drain();
      while (sb.size() != 0) @(negedge clk);
   endtask

   // monitor: compares queued expectations in their cycle
   always @(negedge clk) begin
      while (sb.size() != 0 && sb[0].at <= cyc) begin
         item_t it;
         it = sb.pop_front();
         if (it.at < cyc) check(1'b0, {it.tag, " missed"}, 16'(cyc), 16'(it.at));
         else begin
            check(rst_n === it.rst, {it.tag, " rst_n"}, 16'(rst_n), 16'(it.rst));
            if (it.mask != 0)
               check((rdata & it.mask) === (it.flags & it.mask), {it.tag, " status"},
                     16'(rdata & it.mask), 16'(it.flags & it.mask));
         end
      end
   end

   task automatic supply_up(string tag);
      int c;
      @(negedge clk); c = cyc; supply = 1'b1;
      push(c + 1, 1'b0, '0, '0, "R2");
      push(c + SYNC + POR - 1, 1'b0, '0, '0, tag);
      push(c + SYNC + POR, 1'b1, 3'b001, 3'b001, "R3");
      drain();
   endtask

   task automatic short_pulse(bit use_pin, logic [2:0] expf);
      int c;
      @(negedge clk); c = cyc;
      if (use_pin) pin = 1'b1; else wdog = 1'b1;
      push(c + 1, 1'b0, '0, '0, "R4");
      push(c + SHORT, 1'b0, '0, '0, "R4");
      push(c + SHORT + 1, 1'b1, expf, 3'b111, "R5");
      @(negedge clk); pin = 1'b0; wdog = 1'b0;
      drain();
   endtask

   initial begin
      #2 supply = 1'b0;
      repeat (3) @(negedge clk);
      check(rst_n === 1'b0, "R1 reset state", 16'(rst_n), 16'h0);
      check(vec === 16'h0000, "R9 vector", vec, 16'h0000);

      supply_up("R2");                       // cold rise
      short_pulse(1'b0, 3'b010);             // watchdog
      short_pulse(1'b1, 3'b100);             // pin

      begin : r7_restart
         int c;
         @(negedge clk); c = cyc; wdog = 1'b1;
         @(negedge clk); wdog = 1'b0;
         repeat (3) @(negedge clk);
         c = cyc; pin = 1'b1;
         push(c + SHORT, 1'b0, '0, '0, "R7 restart");
         push(c + SHORT + 1, 1'b1, 3'b100, 3'b111, "R7 restart");
         @(negedge clk); pin = 1'b0;
         drain();
      end

      begin : r6_force_and_priority
         int c;
         @(negedge clk); c = cyc; wr = 1'b1; wdata = 3'b001;
         push(c + 1, 1'b0, 3'b001, 3'b111, "R6");
         @(negedge clk); wr = 1'b0; wdata = '0;
         repeat (8) @(negedge clk);
         c = cyc; wdog = 1'b1;
         push(c + POR, 1'b0, '0, '0, "R7 priority");
         push(c + POR + 1, 1'b1, 3'b001, 3'b111, "R7 priority");
         @(negedge clk); wdog = 1'b0;
         drain();
      end

      begin : r6_plain_force
         int c;
         @(negedge clk); c = cyc; wr = 1'b1; wdata = 3'b111;
         push(c + POR, 1'b0, '0, '0, "R6");
         push(c + POR + 1, 1'b1, 3'b001, 3'b111, "R6");
         @(negedge clk); wr = 1'b0; wdata = '0;
         drain();
      end

      short_pulse(1'b0, 3'b010);
      begin : r8_zero_write
         int c;
         @(negedge clk); c = cyc; wr = 1'b1; wdata = 3'b110;
         push(c + 1, 1'b1, 3'b010, 3'b111, "R8");
         @(negedge clk); wdata = 3'b100;
         push(c + 3, 1'b1, 3'b010, 3'b111, "R8");
         @(negedge clk); wr = 1'b0; wdata = '0;
         drain();
      end

      begin : r10_power_fail
         @(negedge clk); supply = 1'b0;
         #1 check(rst_n === 1'b0, "R1 async drop", 16'(rst_n), 16'h0);
         repeat (3) @(negedge clk);
         check(rst_n === 1'b0, "R1 held", 16'(rst_n), 16'h0);
         supply_up("R10");
      end
      check(vec === 16'h0000, "R9 vector", vec, 16'h0000);

      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_bad++;
         $display("FAIL watchdog expired: actual %0d expected 0", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule